// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Level Flags

This block is a single-clock FIFO carrying 18-bit words, with a depth set by a parameter (a power of two from 256 to 4096). A write enable stores one word per rising clock edge and a read enable takes one word out. A mode input picks the output timing. In standard mode every word has to be read out explicitly. In fall-through mode the head word moves onto the output register by itself, and a read then consumes it.

The same mode input also changes what the two fixed flags mean. In standard mode they report empty and full. In fall-through mode they report output-ready and input-ready. Three level flags are derived from the stored count: half-full, almost-empty and almost-full. The almost thresholds are two offset registers, reached through a load input. While load is high, writes store offsets and reads return them, both stepping through a two-entry sequence that starts at the almost-empty offset. The mode input is meant to change only while reset is held.

Top module: `dmfifo`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) empties the FIFO, clears `rd_data` to 0, and returns both offsets to 7 and the load sequence to the almost-empty offset. After reset, `head_flag` is 1 in standard mode and 0 in fall-through mode, `room_flag` is 0 in standard mode and 1 in fall-through mode, `almost_empty` is 1, and `half_full` and `almost_full` are 0.
- R2: In standard mode (`fwft_mode`=0) with `load` low, a write stores `wr_data`. A read of a non-empty FIFO places the oldest word on `rd_data` after the edge. `rd_data` keeps its value in every other cycle.
- R3: When the stored count is DEPTH at an edge, a write is ignored. In standard mode `room_flag` is 1 (full) exactly when the count equals DEPTH.
- R4: In standard mode, a read while the FIFO is empty is ignored and `rd_data` is unchanged. `head_flag` is 1 (empty) exactly when the count is 0.
- R5: In fall-through mode (`fwft_mode`=1), a word written into an empty FIFO appears on `rd_data` with no read. `head_flag` (output-ready) is still 0 after the write edge and becomes 1 after the following edge.
- R6: In fall-through mode, a read while `head_flag` is 1 consumes the shown word and brings up the next one, or drops `head_flag` if none is stored. While `head_flag` is 1, `rd_data` holds steady without a read. `room_flag` (input-ready) is 1 exactly when the count is below DEPTH.
- R7: `half_full` is 1 exactly when the stored count exceeds DEPTH/2.
- R8: `almost_empty` is 1 exactly when the stored count is at or below the almost-empty offset.
- R9: `almost_full` is 1 exactly when DEPTH minus the stored count is at or below the almost-full offset.
- R10: With `load` high, a write stores `wr_data[AW-1:0]` into the offset the sequence points at. A read with `wr_en` low places that offset, zero-extended, on `rd_data` after the edge. Each such access moves the shared sequence along almost-empty, almost-full, almost-empty, and so on. While `load` is high the FIFO contents are not touched.
- R11: In fall-through mode the word held on the output register counts as stored, so the capacity is DEPTH in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fwft_mode | input | 1 | 0: standard timing, 1: fall-through timing |
| wr_en | input | 1 | Write enable (FIFO write, or offset write when load is high) |
| wr_data | input | 18 | Write data; low AW bits used as offset value during load |
| rd_en | input | 1 | Read enable (FIFO read, or offset readback when load is high) |
| load | input | 1 | Routes writes and reads to the offset registers |
| rd_data | output | 18 | Output register |
| head_flag | output | 1 | Standard: empty; fall-through: output-ready |
| room_flag | output | 1 | Standard: full; fall-through: input-ready |
| half_full | output | 1 | Count above DEPTH/2 |
| almost_empty | output | 1 | Count at or below almost-empty offset |
| almost_full | output | 1 | Free space at or below almost-full offset |

## Verification
A short burst that stays below the default offset shows almost-empty and word ordering without the level flags crossing. A complete fill to DEPTH with one surplus write, followed by a full drain, separates the exact crossing points of half-full, almost-full and full from an off-by-one, and shows that a surplus write or a surplus read is dropped. The fall-through run with one isolated word tells a two-edge output latency from a one-edge or three-edge latency. Filling that mode to capacity shows whether the output register is counted. The load sequence, with writes followed by three readbacks, separates a shared wrapping pointer from separate or non-wrapping ones, and a following small fill checks that a loaded offset really moves the almost-empty threshold.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;
    localparam int DATA_W = 18;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/dmfifo_store.sv
module dmfifo_store #(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dmfifo_ofs.sv
module dmfifo_ofs
    import dmfifo_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DEF_OFS = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] wr_val,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off,
    output logic [AW-1:0] rb_val
);
    typedef struct packed {
        ofs_sel_e      sel;
        logic [AW-1:0] ae;
        logic [AW-1:0] af;
    } ofs_state_t;

    localparam logic [AW-1:0] DEF_L = AW'(DEF_OFS);

    ofs_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load && wr_en) begin
            if (st_q.sel == SEL_AE) begin
                st_d.ae = wr_val;
            end else begin
                st_d.af = wr_val;
            end
        end
        if (load && (wr_en || rd_en)) begin
            st_d.sel = (st_q.sel == SEL_AE) ? SEL_AF : SEL_AE;
        end
        if (rst) begin
            st_d.sel = SEL_AE;
            st_d.ae  = DEF_L;
            st_d.af  = DEF_L;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ae_off = st_q.ae;
    assign af_off = st_q.af;
    assign rb_val = (st_q.sel == SEL_AE) ? st_q.ae : st_q.af;
endmodule

// File: rtl/dmfifo_flags.sv
module dmfifo_flags #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          fwft_mode,
    input  logic [AW:0]   level,
    input  logic          out_valid,
    input  logic [AW-1:0] ae_off,
    input  logic [AW-1:0] af_off,
    output logic          head_flag,
    output logic          room_flag,
    output logic          half_full,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_L  = (AW+1)'(DEPTH / 2);

    logic [AW:0] free_w;

    always_comb begin
        free_w       = DEPTH_L - level;
        half_full    = level > HALF_L;
        almost_empty = level <= {1'b0, ae_off};
        almost_full  = free_w <= {1'b0, af_off};
        if (fwft_mode) begin
            head_flag = out_valid;
            room_flag = level < DEPTH_L;
        end else begin
            head_flag = level == '0;
            room_flag = level == DEPTH_L;
        end
    end
endmodule

// File: rtl/dmfifo.sv
module dmfifo
    import dmfifo_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int DEF_OFS = 7,
    parameter int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fwft_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              load,
    output logic [DATA_W-1:0] rd_data,
    output logic              head_flag,
    output logic              room_flag,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [AW:0]       mcnt;
        logic              ovld;
        logic [DATA_W-1:0] dout;
    } core_state_t;

    core_state_t cs_q, cs_d;

    logic [AW:0]       level;
    logic              push;
    logic              mem_pop;
    logic              consume;
    logic [DATA_W-1:0] mem_rdata;
    logic [AW-1:0]     ae_off, af_off, rb_val;

    dmfifo_store #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (cs_q.wptr),
        .wdata (wr_data),
        .raddr (cs_q.rptr),
        .rdata (mem_rdata)
    );

    dmfifo_ofs #(.AW(AW), .DEF_OFS(DEF_OFS)) u_ofs (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_val (wr_data[AW-1:0]),
        .ae_off (ae_off),
        .af_off (af_off),
        .rb_val (rb_val)
    );

    dmfifo_flags #(.DEPTH(DEPTH), .AW(AW)) u_flags (
        .fwft_mode    (fwft_mode),
        .level        (level),
        .out_valid    (cs_q.ovld),
        .ae_off       (ae_off),
        .af_off       (af_off),
        .head_flag    (head_flag),
        .room_flag    (room_flag),
        .half_full    (half_full),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

    // Stored count: memory words plus the output register in fall-through mode
    assign level = cs_q.mcnt + {{AW{1'b0}}, cs_q.ovld};
    assign push  = wr_en && !load && (level < DEPTH_L) && !rst;

    always_comb begin
        cs_d    = cs_q;
        mem_pop = 1'b0;
        consume = 1'b0;

        if (!fwft_mode) begin
            cs_d.ovld = 1'b0;
            if (rd_en && !load && (cs_q.mcnt != '0)) begin
                mem_pop   = 1'b1;
                cs_d.dout = mem_rdata;
            end
        end else begin
            consume = rd_en && !load && cs_q.ovld;
            if ((cs_q.mcnt != '0) && (!cs_q.ovld || consume)) begin
                mem_pop   = 1'b1;
                cs_d.dout = mem_rdata;
                cs_d.ovld = 1'b1;
            end else if (consume) begin
                cs_d.ovld = 1'b0;
            end
        end

        if (load && rd_en && !wr_en) begin
            cs_d.dout = {{(DATA_W-AW){1'b0}}, rb_val};
        end

        if (push) begin
            cs_d.wptr = cs_q.wptr + 1'b1;
        end
        if (mem_pop) begin
            cs_d.rptr = cs_q.rptr + 1'b1;
        end
        case ({push, mem_pop})
            2'b10:   cs_d.mcnt = cs_q.mcnt + 1'b1;
            2'b01:   cs_d.mcnt = cs_q.mcnt - 1'b1;
            default: cs_d.mcnt = cs_q.mcnt;
        endcase

        if (rst) begin
            cs_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cs_q <= cs_d;
    end

    assign rd_data = cs_q.dout;
endmodule

// File: rtl/dmfifo_chk.sv
module dmfifo_chk #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst,
    input logic        fwft_mode,
    input logic        wr_en,
    input logic        rd_en,
    input logic        load,
    input logic        head_flag,
    input logic [17:0] rd_data,
    input logic [AW:0] level
);
    logic armed_q;

    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (level == '0 && rd_data == '0));

    p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (level == (AW+1)'(DEPTH) && !rd_en) |=> level == (AW+1)'(DEPTH));

    p_empty_read_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!fwft_mode && level == '0 && !wr_en && !load) |=> $stable(rd_data));

    p_fwft_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (fwft_mode && head_flag && !rd_en && !load) |=> (head_flag && $stable(rd_data)));

    p_load_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        (load && armed_q) |=> level == $past(level));

    p_level_step_r11: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (level == $past(level) || level == $past(level) + 1'b1
                     || level + 1'b1 == $past(level)));
endmodule

bind dmfifo dmfifo_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fwft_mode (fwft_mode),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .load      (load),
    .head_flag (head_flag),
    .rd_data   (rd_data),
    .level     (level)
);

// File: tb/tb_dmfifo.sv
`timescale 1ns/1ps
module tb_dmfifo;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fwft_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        load = 1'b0;
    logic [17:0] rd_data;
    logic        head_flag, room_flag, half_full, almost_empty, almost_full;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [17:0] sb_q[$];
    bit          std_pend = 0;
    logic [17:0] std_exp;

    always #2.5 clk = ~clk;

    dmfifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .fwft_mode(fwft_mode),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .load(load),
        .rd_data(rd_data), .head_flag(head_flag), .room_flag(room_flag),
        .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected words as the design produces them
    always @(posedge clk) begin
        if (!rst && !load && rd_en && !fwft_mode && sb_q.size() > 0) begin
            std_exp  = sb_q.pop_front();
            std_pend = 1;
        end
        if (!rst && !load && rd_en && fwft_mode && head_flag) begin
            if (sb_q.size() == 0) begin
                chk("R6 read with nothing expected", 1, 0);
            end else begin
                chk("R6 fall-through data order", int'(rd_data), int'(sb_q.pop_front()));
            end
        end
    end

    always @(negedge clk) begin
        if (std_pend) begin
            std_pend = 0;
            chk("R2 standard data order", int'(rd_data), int'(std_exp));
        end
    end

    // Driver tasks: called and returning at a falling edge
    task automatic wr(input logic [17:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        if (!load && sb_q.size() < DEPTH) sb_q.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset(input logic mode);
        rst       = 1'b1;
        fwft_mode = mode;
        sb_q.delete();
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [17:0] last;
        @(negedge clk);
        do_reset(1'b0);
        // R1 reset state in standard mode
        chk("R1 head_flag (empty)", head_flag, 1);
        chk("R1 room_flag (full)", room_flag, 0);
        chk("R1 almost_empty", almost_empty, 1);
        chk("R1 half_full", half_full, 0);
        chk("R1 almost_full", almost_full, 0);
        chk("R1 rd_data", int'(rd_data), 0);

        // R2 short burst, R8 below default offset
        for (int i = 0; i < 5; i++) wr(18'(16'hA000 + i));
        chk("R4 not empty after writes", head_flag, 0);
        chk("R8 almost_empty at count 5", almost_empty, 1);
        for (int i = 0; i < 5; i++) rd();
        chk("R4 empty after drain", head_flag, 1);
        last = rd_data;
        rd();
        chk("R4 read on empty keeps rd_data", int'(rd_data), int'(last));

        // Full fill with level flag boundaries
        for (int i = 0; i < DEPTH; i++) begin
            wr(18'(i * 3 + 1));
            if (i + 1 == 7)   chk("R8 almost_empty at count 7", almost_empty, 1);
            if (i + 1 == 8)   chk("R8 almost_empty at count 8", almost_empty, 0);
            if (i + 1 == 128) chk("R7 half_full at count 128", half_full, 0);
            if (i + 1 == 129) chk("R7 half_full at count 129", half_full, 1);
            if (i + 1 == 248) chk("R9 almost_full at free 8", almost_full, 0);
            if (i + 1 == 249) chk("R9 almost_full at free 7", almost_full, 1);
            if (i + 1 == 255) chk("R3 full flag at count 255", room_flag, 0);
        end
        chk("R3 full flag at DEPTH", room_flag, 1);
        wr(18'h3FFFF);
        chk("R3 full flag after surplus write", room_flag, 1);
        for (int i = 0; i < DEPTH; i++) rd();
        chk("R3 surplus write not stored (empty after DEPTH reads)", head_flag, 1);
        last = rd_data;
        rd();
        chk("R4 surplus read keeps rd_data", int'(rd_data), int'(last));

        // R10 offset load sequence
        do_reset(1'b0);
        load = 1'b1;
        wr(18'd3);
        wr(18'd10);
        rd();
        chk("R10 readback first is almost-empty offset", int'(rd_data), 3);
        rd();
        chk("R10 readback second is almost-full offset", int'(rd_data), 10);
        rd();
        chk("R10 readback wraps to almost-empty offset", int'(rd_data), 3);
        load = 1'b0;
        @(negedge clk);
        chk("R10 load writes left FIFO empty", head_flag, 1);
        for (int i = 0; i < 3; i++) wr(18'(i + 50));
        chk("R8 almost_empty at count 3, offset 3", almost_empty, 1);
        wr(18'd53);
        chk("R8 almost_empty at count 4, offset 3", almost_empty, 0);
        for (int i = 0; i < 4; i++) rd();
        do_reset(1'b0);
        load = 1'b1;
        rd();
        chk("R1 reset restores offset 7 and sequence start", int'(rd_data), 7);
        load = 1'b0;

        // Fall-through mode
        do_reset(1'b1);
        chk("R1 fall-through output-ready low", head_flag, 0);
        chk("R1 fall-through input-ready high", room_flag, 1);
        wr(18'h0002A);
        chk("R5 not ready one edge after write", head_flag, 0);
        @(negedge clk);
        chk("R5 ready two edges after write", head_flag, 1);
        chk("R5 head word shown without read", int'(rd_data), 'h2A);
        for (int i = 0; i < 3; i++) wr(18'(i + 200));
        @(negedge clk);
        for (int i = 0; i < 4; i++) rd();
        chk("R6 output-ready drops after last read", head_flag, 0);

        // R11 capacity in fall-through mode
        for (int i = 0; i < DEPTH; i++) wr(18'(i + 7000));
        repeat (2) @(negedge clk);
        chk("R11 input-ready low at DEPTH", room_flag, 0);
        chk("R11 almost_full at DEPTH", almost_full, 1);
        wr(18'h15555);
        rd_en = 1'b1;
        while (head_flag) @(negedge clk);
        rd_en = 1'b0;
        chk("R11 all words drained, no extra", sb_q.size(), 0);
        chk("R6 input-ready high when empty", room_flag, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule